// File: doc/BRIEF.md
# Interrupt Pending, Mask and Timer-Compare Collector

This block gathers every interrupt source of a processor core and reduces them to one maskable request line and one non-maskable pulse. Eight pending bits sit in a cause register: two that software sets and clears, five that track external request lines, and one timer bit. The timer bit is set either when a free-running count register equals a compare register, or when one of two performance counters crosses into its top bit. Each pending bit has its own mask bit in a status register, and a single global enable in the same register gates the whole maskable path. No pending bit outranks another.

Software reaches the registers through a single-cycle write-enable/address port with a combinational read path. A separate non-maskable input is turned into a one-cycle pulse on its rising edge and bypasses every mask. The exception vector and the pipeline that consumes the requests are outside this block.

Top module: `irq_gather`

## Requirements
- R1: After reset, status reads 0, cause reads 0, compare reads 0xFFFFFFFF, both performance counters read 0, and irq_o and nmi_o are low.
- R2: Register addresses: 0 status (bit 0 global enable, bits 15:8 mask bits IM0..IM7), 1 cause (bits 15:8 pending bits IP0..IP7, IP0 at bit 8), 2 count, 3 compare, 4 performance counter 0, 5 performance counter 1. Addresses 6 and 7 read 0 and writes to them change no register.
- R3: A write to cause loads IP0 and IP1 from write-data bits 8 and 9 at the next clock edge; all other cause bits ignore the write.
- R4: IP2..IP6 show hw_irq_i[0]..hw_irq_i[4] as sampled at the previous clock edge.
- R5: The count register increments by one on every clock; a write loads it with the write data instead.
- R6: IP7 is set at the clock edge after count equals compare and stays set until compare is written; a set event in the same cycle as a compare write leaves IP7 set.
- R7: Performance counter k increments on each clock with perf_evt_i[k] high and is loaded by a write; an increment from 0x7FFFFFFF to 0x80000000 sets IP7, and no other change of the counter does.
- R8: irq_o is high exactly when the global enable is set and at least one bit of (IP AND IM) is 1; every source reaches irq_o alone, without priority among sources.
- R9: With the global enable clear, irq_o stays low whatever the pending and mask bits are.
- R10: A rising edge of nmi_i produces nmi_o high for exactly one clock cycle, beginning at the clock edge that samples the new high level, regardless of status; holding nmi_i high gives no further pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hw_irq_i | input | 5 | External level interrupt request lines |
| perf_evt_i | input | 2 | Count-enable events for the two performance counters |
| nmi_i | input | 1 | Non-maskable interrupt request |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i, combinational |
| irq_o | output | 1 | Maskable interrupt request |
| nmi_o | output | 1 | Non-maskable interrupt pulse |

## Verification
A wrong pending or mask bit shows on irq_o within the same cycle that it is stored, and on the cause or status read-back at once, so each mask/pending pattern is checked one cycle after it is written. A timer bit set one edge early or late is caught by sampling IP7 on each cycle around the count/compare match and around the performance-counter wrap into bit 31. A non-maskable pulse that is missing, too long, or repeated while the input stays high shows on nmi_o within two cycles of the edge.

// File: rtl/irq_gather_pkg.sv
package irq_gather_pkg;
  localparam int ADDR_W  = 3;
  localparam int IP_LSB  = 8;   // pending and mask fields start here
  localparam logic [ADDR_W-1:0] ADR_STATUS    = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_CAUSE     = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_COUNT     = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_COMPARE   = 3'd3;
  localparam int                ADR_PERF_BASE = 4;
endpackage

// File: rtl/irq_perf_cnt.sv
module irq_perf_cnt #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         evt_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o
);
  localparam logic [W-1:0] EDGE_VAL = {1'b0, {(W-1){1'b1}}};

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (we_i)   cnt_q <= wdata_i;
    else if (evt_i)  cnt_q <= cnt_q + 1'b1;
  end

  // top bit set by counting only, not by a load
  assign ovf_o = evt_i && !we_i && (cnt_q == EDGE_VAL);
  assign cnt_o = cnt_q;

  assert_perf_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && !we_i && cnt_q == EDGE_VAL) |=> cnt_q[W-1]);
  assert_perf_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!evt_i && !we_i) |=> $stable(cnt_q));
endmodule

// File: rtl/irq_timer.sv
module irq_timer #(
  parameter int CNT_W    = 32,
  parameter int NUM_PERF = 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           cnt_we_i,
  input  logic                           cmp_we_i,
  input  logic [NUM_PERF-1:0]            perf_we_i,
  input  logic [CNT_W-1:0]               wdata_i,
  input  logic [NUM_PERF-1:0]            perf_evt_i,
  output logic [CNT_W-1:0]               count_o,
  output logic [CNT_W-1:0]               compare_o,
  output logic [NUM_PERF-1:0][CNT_W-1:0] perf_o,
  output logic                           tick_o
);
  logic [CNT_W-1:0]    count_q, compare_q;
  logic [NUM_PERF-1:0] perf_ovf;
  logic                tick_q, tick_set;

  for (genvar k = 0; k < NUM_PERF; k++) begin : g_perf
    irq_perf_cnt #(.W(CNT_W)) u_perf (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .evt_i   (perf_evt_i[k]),
      .we_i    (perf_we_i[k]),
      .wdata_i (wdata_i),
      .cnt_o   (perf_o[k]),
      .ovf_o   (perf_ovf[k])
    );
  end

  assign tick_set = (count_q == compare_q) || (|perf_ovf);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q   <= '0;
      compare_q <= '1;
      tick_q    <= 1'b0;
    end else begin
      count_q <= cnt_we_i ? wdata_i : count_q + 1'b1;
      if (cmp_we_i) compare_q <= wdata_i;
      // a set event outranks the clearing compare write
      if (tick_set)      tick_q <= 1'b1;
      else if (cmp_we_i) tick_q <= 1'b0;
    end
  end

  assign count_o   = count_q;
  assign compare_o = compare_q;
  assign tick_o    = tick_q;

  assert_match_sets_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == compare_o) |=> tick_o);
  assert_cmp_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_we_i && count_o != compare_o && perf_ovf == '0) |=> !tick_o);
  assert_tick_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !cmp_we_i) |=> tick_o);
  assert_ovf_sets_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|perf_ovf) |=> tick_o);
endmodule

// File: rtl/irq_nmi_edge.sv
module irq_nmi_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nmi_i,
  output logic pulse_o
);
  logic lvl_q, pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      lvl_q   <= nmi_i;
      pulse_q <= nmi_i && !lvl_q;
    end
  end

  assign pulse_o = pulse_q;

  assert_nmi_one_cycle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
  assert_nmi_rise_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_i && !lvl_q) |=> pulse_o);
endmodule

// File: rtl/irq_gather.sv
module irq_gather
  import irq_gather_pkg::*;
#(
  parameter int NUM_HW   = 5,
  parameter int NUM_SW   = 2,
  parameter int NUM_PERF = 2,
  parameter int DATA_W   = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_HW-1:0]   hw_irq_i,
  input  logic [NUM_PERF-1:0] perf_evt_i,
  input  logic                nmi_i,
  input  logic                reg_we_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  output logic                irq_o,
  output logic                nmi_o
);
  localparam int NUM_IP = NUM_SW + NUM_HW + 1;
  localparam int HW_LSB = NUM_SW;

  logic                           ie_q;
  logic [NUM_IP-1:0]              im_q;
  logic [NUM_SW-1:0]              sw_q;
  logic [NUM_HW-1:0]              hw_q;
  logic [NUM_IP-1:0]              ip;
  logic                           tick;
  logic [DATA_W-1:0]              count, compare;
  logic [NUM_PERF-1:0][DATA_W-1:0] perf;
  logic                           st_we, cause_we, cnt_we, cmp_we;
  logic [NUM_PERF-1:0]            perf_we;

  assign st_we    = reg_we_i && (reg_addr_i == ADR_STATUS);
  assign cause_we = reg_we_i && (reg_addr_i == ADR_CAUSE);
  assign cnt_we   = reg_we_i && (reg_addr_i == ADR_COUNT);
  assign cmp_we   = reg_we_i && (reg_addr_i == ADR_COMPARE);

  for (genvar k = 0; k < NUM_PERF; k++) begin : g_pwe
    assign perf_we[k] = reg_we_i && (reg_addr_i == ADDR_W'(ADR_PERF_BASE + k));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q <= 1'b0;
      im_q <= '0;
      sw_q <= '0;
      hw_q <= '0;
    end else begin
      hw_q <= hw_irq_i;
      if (st_we) begin
        ie_q <= reg_wdata_i[0];
        im_q <= reg_wdata_i[IP_LSB +: NUM_IP];
      end
      if (cause_we) sw_q <= reg_wdata_i[IP_LSB +: NUM_SW];
    end
  end

  irq_timer #(.CNT_W(DATA_W), .NUM_PERF(NUM_PERF)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_we_i   (cnt_we),
    .cmp_we_i   (cmp_we),
    .perf_we_i  (perf_we),
    .wdata_i    (reg_wdata_i),
    .perf_evt_i (perf_evt_i),
    .count_o    (count),
    .compare_o  (compare),
    .perf_o     (perf),
    .tick_o     (tick)
  );

  irq_nmi_edge u_nmi (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .nmi_i   (nmi_i),
    .pulse_o (nmi_o)
  );

  assign ip    = {tick, hw_q, sw_q};
  assign irq_o = ie_q && (|(ip & im_q));

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      ADR_STATUS: begin
        reg_rdata_o[0]                 = ie_q;
        reg_rdata_o[IP_LSB +: NUM_IP]  = im_q;
      end
      ADR_CAUSE:   reg_rdata_o[IP_LSB +: NUM_IP] = ip;
      ADR_COUNT:   reg_rdata_o = count;
      ADR_COMPARE: reg_rdata_o = compare;
      default: begin
        for (int k = 0; k < NUM_PERF; k++)
          if (reg_addr_i == ADDR_W'(ADR_PERF_BASE + k)) reg_rdata_o = perf[k];
      end
    endcase
  end

  assert_sw_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause_we |=> sw_q == $past(reg_wdata_i[IP_LSB +: NUM_SW]));
  assert_sw_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cause_we |=> $stable(sw_q));
  assert_hw_follow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ip[HW_LSB +: NUM_HW] == $past(hw_irq_i));
  assert_hw_reach_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ie_q && im_q[HW_LSB] && hw_irq_i[0] && !st_we) |=> irq_o);
  assert_gate_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ie_q && !st_we) |=> !irq_o);
endmodule

// File: tb/sim_irq_gather.sv
`timescale 1ns/1ps
module sim_irq_gather;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  hw = '0;
  logic [1:0]  pevt = '0;
  logic        nmi = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  adr = '0;
  logic [31:0] wd = '0;
  logic [31:0] rd;
  logic        irq, nmi_p;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  irq_gather u0 (
    .clk_i(clk), .rst_ni(rst_n), .hw_irq_i(hw), .perf_evt_i(pevt), .nmi_i(nmi),
    .reg_we_i(we), .reg_addr_i(adr), .reg_wdata_i(wd), .reg_rdata_o(rd),
    .irq_o(irq), .nmi_o(nmi_p)
  );

  // {ie, im[7:0], sw[1:0], hw[4:0], expected irq}
  localparam logic [16:0] VEC [10] = '{
    {1'b1, 8'h01, 2'b01, 5'b00000, 1'b1},
    {1'b1, 8'h02, 2'b01, 5'b00000, 1'b0},
    {1'b1, 8'h02, 2'b10, 5'b00000, 1'b1},
    {1'b0, 8'hFF, 2'b11, 5'b11111, 1'b0},
    {1'b1, 8'h04, 2'b00, 5'b00001, 1'b1},
    {1'b1, 8'h40, 2'b00, 5'b10000, 1'b1},
    {1'b1, 8'h40, 2'b00, 5'b01111, 1'b0},
    {1'b1, 8'h80, 2'b11, 5'b11111, 1'b0},
    {1'b1, 8'h3C, 2'b00, 5'b00100, 1'b1},
    {1'b1, 8'h00, 2'b11, 5'b11111, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; adr = a; wd = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rdreg(input logic [2:0] a, output logic [31:0] d);
    adr = a;
    #1;
    d = rd;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fin;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    fin();
  end

  initial begin
    logic [31:0] v, v2;
    repeat (3) @(negedge clk);
    // R1 reset state, checked while reset is held
    rdreg(3'd0, v); chk("R1 status", v, 32'h0);
    rdreg(3'd1, v); chk("R1 cause", v, 32'h0);
    rdreg(3'd3, v); chk("R1 compare", v, 32'hFFFF_FFFF);
    rdreg(3'd4, v); chk("R1 perf0", v, 32'h0);
    rdreg(3'd5, v); chk("R1 perf1", v, 32'h0);
    rdreg(3'd2, v); chk("R1 count", v, 32'h0);
    chk("R1 irq_o", {31'b0, irq}, 32'h0);
    chk("R1 nmi_o", {31'b0, nmi_p}, 32'h0);
    rst_n = 1'b1;
    cyc(1);

    // R8 R9 R3 R4 table
    foreach (VEC[i]) begin
      logic [16:0] t;
      t = VEC[i];
      wr(3'd0, {16'h0, t[15:8], 7'h0, t[16]});
      @(negedge clk);
      we = 1'b1; adr = 3'd1; wd = {16'hFFFF, 6'h3F, t[7:6], 8'hFF}; hw = t[5:1];
      @(negedge clk);
      we = 1'b0;
      chk(t[16] ? "R8 irq_o" : "R9 irq_o", {31'b0, irq}, {31'b0, t[0]});
      rdreg(3'd1, v); chk("R3 R4 cause", v, {16'h0, 1'b0, t[5:1], t[7:6], 8'h0});
      rdreg(3'd0, v); chk("R2 status", v, {16'h0, t[15:8], 7'h0, t[16]});
    end
    hw = '0;
    wr(3'd1, 32'h0);
    wr(3'd0, 32'h0);

    // R2 unmapped addresses
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    rdreg(3'd7, v); chk("R2 unmapped read", v, 32'h0);
    rdreg(3'd0, v); chk("R2 unmapped write status", v, 32'h0);
    rdreg(3'd1, v); chk("R2 unmapped write cause", v, 32'h0);
    rdreg(3'd3, v); chk("R2 unmapped write compare", v, 32'hFFFF_FFFF);

    // R5 count
    wr(3'd2, 32'd1000);
    rdreg(3'd2, v); chk("R5 count load", v, 32'd1000);
    cyc(3);
    rdreg(3'd2, v); chk("R5 count step", v, 32'd1003);

    // R6 compare match
    wr(3'd3, 32'd100);
    wr(3'd2, 32'd97);
    rdreg(3'd1, v); chk("R6 ip7 before", {31'b0, v[15]}, 32'h0);
    cyc(2);
    rdreg(3'd1, v); chk("R6 ip7 count 99", {31'b0, v[15]}, 32'h0);
    cyc(1);
    rdreg(3'd1, v); chk("R6 ip7 at match", {31'b0, v[15]}, 32'h0);
    cyc(1);
    rdreg(3'd1, v); chk("R6 ip7 after match", {31'b0, v[15]}, 32'h1);
    cyc(5);
    rdreg(3'd1, v); chk("R6 ip7 sticky", {31'b0, v[15]}, 32'h1);
    wr(3'd0, 32'h0000_8001);
    chk("R8 timer irq_o", {31'b0, irq}, 32'h1);
    wr(3'd3, 32'hFFFF_FFFF);
    rdreg(3'd1, v); chk("R6 compare write clears", {31'b0, v[15]}, 32'h0);
    chk("R6 irq_o drops", {31'b0, irq}, 32'h0);

    // R7 performance counters
    for (int k = 0; k < 2; k++) begin
      wr(3'(4 + k), 32'h7FFF_FFFE);
      cyc(2);
      rdreg(3'(4 + k), v); chk("R7 perf idle", v, 32'h7FFF_FFFE);
      @(negedge clk); pevt[k] = 1'b1;
      @(negedge clk); pevt[k] = 1'b0;
      rdreg(3'(4 + k), v); chk("R7 perf step", v, 32'h7FFF_FFFF);
      rdreg(3'd1, v2); chk("R7 no early ip7", {31'b0, v2[15]}, 32'h0);
      @(negedge clk); pevt[k] = 1'b1;
      @(negedge clk); pevt[k] = 1'b0;
      rdreg(3'(4 + k), v); chk("R7 perf wrap value", v, 32'h8000_0000);
      rdreg(3'd1, v2); chk("R7 wrap sets ip7", {31'b0, v2[15]}, 32'h1);
      chk("R7 irq_o", {31'b0, irq}, 32'h1);
      wr(3'd3, 32'hFFFF_FFFF);
      @(negedge clk); pevt[k] = 1'b1;
      @(negedge clk); pevt[k] = 1'b0;
      rdreg(3'd1, v2); chk("R7 no set past wrap", {31'b0, v2[15]}, 32'h0);
      wr(3'(4 + k), 32'hFFFF_FFFF);
      rdreg(3'd1, v2); chk("R7 load no set", {31'b0, v2[15]}, 32'h0);
      wr(3'(4 + k), 32'h0);
      rdreg(3'(4 + k), v); chk("R7 perf clear", v, 32'h0);
    end

    // R10 NMI with everything masked
    wr(3'd0, 32'h0);
    @(negedge clk); nmi = 1'b1;
    chk("R10 nmi before edge", {31'b0, nmi_p}, 32'h0);
    @(negedge clk);
    chk("R10 nmi pulse", {31'b0, nmi_p}, 32'h1);
    @(negedge clk);
    chk("R10 nmi pulse ends", {31'b0, nmi_p}, 32'h0);
    cyc(4);
    chk("R10 nmi held no repeat", {31'b0, nmi_p}, 32'h0);
    nmi = 1'b0;
    cyc(2);
    nmi = 1'b1;
    @(negedge clk);
    chk("R10 nmi second pulse", {31'b0, nmi_p}, 32'h1);
    nmi = 1'b0;
    @(negedge clk);
    chk("R10 nmi second ends", {31'b0, nmi_p}, 32'h0);
    chk("R10 irq_o unaffected", {31'b0, irq}, 32'h0);

    fin();
  end
endmodule